// File: doc/BRIEF.md
# Memory Power-State Controller

This block tracks the power mode of one packet-addressed memory device. The device is awake in either an attention mode or a standby mode. It moves between these two modes when it receives row/column opcode packets. A non-broadcast packet addressed to this device can put it into one of two sleep modes: a light nap or a deep power-down. While the device sleeps it accepts no packets.

Sleep ends through a serial wake-up sequence on a command wire. The wire is sampled on strobe cycles that mark falling edges of the serial clock. The sequence is a start bit followed by a device address. When the address matches the device's own ID, the block counts a programmable number of further strobes and then wakes. That count is taken from a nap-exit field or a power-down-exit field, depending on which sleep mode the device is in. On waking, the device returns to the awake mode it held before sleeping and pulses a ready flag.

Two hold-off windows guard the transitions. The first forbids re-entering sleep for a time after a wake. The second forbids leaving sleep for a time after entry. A request that arrives inside either window is kept until the window closes.

Top module: `pmc_power_ctrl`

## Requirements
- R1: After reset the mode output is attention (code 0), `accept_o` is 1, `ready_o` is 0, and both exit-count fields hold 1.
- R2: While awake, a valid packet with opcode 1 (go to attention) or opcode 2 (go to standby) sets the mode to 0 or 1 one cycle later. The packet must either be broadcast or carry this device's ID. A packet with another device's ID and no broadcast flag leaves the mode unchanged.
- R3: While awake, a non-broadcast packet for this device with opcode 3 puts the device into nap (code 2), and opcode 4 puts it into power-down (code 3), one cycle later. A broadcast packet with opcode 3 or 4 is ignored.
- R4: In nap or power-down, `accept_o` is 0 and every packet is ignored.
- R5: A wake-up sequence is sampled only on cycles with `wake_strobe_i` high. It is a 1 start bit followed by the ID_W address bits, most significant first. Only a sequence whose address equals `dev_id_i` arms the exit; any other address has no effect.
- R6: Once armed, the device wakes on the Nth later strobe. N is the nap-exit field in nap and the power-down-exit field in power-down. A field value of 0 acts as 1.
- R7: `ready_o` is high for exactly one cycle: the first cycle in which the mode is awake again after a sleep.
- R8: For REENTRY_CYC cycles after a wake, a sleep request is held pending. The device enters sleep once that window expires.
- R9: A write with `cfg_we_i` high stores `cfg_wdata_i` in the nap-exit field when `cfg_sel_i` is 0, and in the power-down-exit field when `cfg_sel_i` is 1.
- R10: On waking, the mode returns to the awake mode (attention or standby) held just before sleep entry.
- R11: For REEXIT_CYC cycles after sleep entry, strobes on an armed device are not counted toward the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| dev_id_i | input | ID_W | This device's ID |
| pkt_valid_i | input | 1 | Packet present this cycle |
| pkt_dev_i | input | ID_W | Packet target ID |
| pkt_bcast_i | input | 1 | Packet is broadcast |
| pkt_op_i | input | 3 | Opcode: 1 attention, 2 standby, 3 nap, 4 power-down |
| cfg_we_i | input | 1 | Exit-field write enable |
| cfg_sel_i | input | 1 | 0 nap-exit field, 1 power-down-exit field |
| cfg_wdata_i | input | XW | Exit-field write value |
| wake_strobe_i | input | 1 | Serial-clock falling-edge marker |
| wake_bit_i | input | 1 | Command-wire bit |
| mode_o | output | 2 | 0 attention, 1 standby, 2 nap, 3 power-down |
| accept_o | output | 1 | Packets are accepted |
| ready_o | output | 1 | One-cycle wake-complete pulse |

## Verification
The hardest case to reach is a wake-up whose address match lands inside the re-exit window. In that case the exit count must stall rather than advance or restart. The stimulus sends a nap request and immediately follows it with a matching wake sequence, which takes fewer cycles than the window. It then issues one strobe while the window is still open, waits, and issues another, with the nap-exit field programmed to 0. A similar back-to-back ordering keeps a power-down request pending through the re-entry window. That request comes after an attention packet, so the mode stored for the later wake is the one set just before entry.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      MODE_ATTN = 2'd0,
      MODE_STBY = 2'd1,
      MODE_NAP  = 2'd2,
      MODE_PDN  = 2'd3
   } pmc_mode_e;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_ATTN = 3'd1,
      OP_STBY = 3'd2,
      OP_NAP  = 3'd3,
      OP_PDN  = 3'd4
   } pmc_op_e;
endpackage

// File: rtl/pmc_holdoff.sv
module pmc_holdoff #(
   parameter int unsigned DELAY = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   localparam int unsigned CW = $clog2(DELAY + 1);

   if (DELAY < 1) begin : g_bad_delay
      $error("pmc_holdoff: DELAY must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (start_i)       cnt_q <= CW'(DELAY);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pmc_wake_rx.sv
module pmc_wake_rx #(
   parameter int unsigned ID_W      = 6,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic            strobe_i,
   input  logic            bit_i,
   input  logic [ID_W-1:0] id_i,
   output logic            hit_o
);
   localparam int unsigned CNTW = $clog2(ID_W);

   if (ID_W < 2) begin : g_bad_width
      $error("pmc_wake_rx: ID_W must be at least 2");
   end

   logic            active_q;
   logic [CNTW-1:0] cnt_q;
   logic [ID_W-1:0] sh_q, sh_next;
   logic            last_bit;

   if (MSB_FIRST) begin : g_msb
      assign sh_next = {sh_q[ID_W-2:0], bit_i};
   end else begin : g_lsb
      assign sh_next = {bit_i, sh_q[ID_W-1:1]};
   end

   assign last_bit = (cnt_q == CNTW'(ID_W - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         sh_q     <= '0;
      end else if (!en_i) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         sh_q     <= '0;
      end else if (strobe_i) begin
         if (!active_q) begin
            active_q <= bit_i;
            cnt_q    <= '0;
            sh_q     <= '0;
         end else begin
            sh_q <= sh_next;
            if (last_bit) active_q <= 1'b0;
            else          cnt_q    <= cnt_q + 1'b1;
         end
      end
   end

   assign hit_o = en_i && strobe_i && active_q && last_bit && (sh_next == id_i);
endmodule

// File: rtl/pmc_exit_regs.sv
module pmc_exit_regs #(
   parameter int unsigned XW        = 4,
   parameter int unsigned RESET_VAL = 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic          sel_i,
   input  logic [XW-1:0] wdata_i,
   output logic [XW-1:0] napx_o,
   output logic [XW-1:0] pdnx_o
);
   if (RESET_VAL >= (1 << XW)) begin : g_bad_reset
      $error("pmc_exit_regs: RESET_VAL does not fit in XW bits");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         napx_o <= XW'(RESET_VAL);
         pdnx_o <= XW'(RESET_VAL);
      end else if (we_i) begin
         if (sel_i) pdnx_o <= wdata_i;
         else       napx_o <= wdata_i;
      end
   end
endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
   import pmc_pkg::*;
#(
   parameter int unsigned ID_W        = 6,
   parameter int unsigned XW          = 4,
   parameter int unsigned REENTRY_CYC = 8,
   parameter int unsigned REEXIT_CYC  = 24,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [ID_W-1:0] dev_id_i,
   input  logic            pkt_valid_i,
   input  logic [ID_W-1:0] pkt_dev_i,
   input  logic            pkt_bcast_i,
   input  logic [2:0]      pkt_op_i,
   input  logic            cfg_we_i,
   input  logic            cfg_sel_i,
   input  logic [XW-1:0]   cfg_wdata_i,
   input  logic            wake_strobe_i,
   input  logic            wake_bit_i,
   output logic [1:0]      mode_o,
   output logic            accept_o,
   output logic            ready_o
);
   if (XW < 1) begin : g_bad_xw
      $error("pmc_power_ctrl: XW must be at least 1");
   end

   pmc_mode_e     mode_q, prev_q;
   logic          pend_q, pend_pdn_q;
   logic          armed_q;
   logic [XW-1:0] left_q;
   logic          ready_q;

   logic          is_sleep, pkt_hit, sleep_req, want_sleep, want_pdn, enter, exit_fire;
   logic          rx_hit, reentry_busy, reexit_busy;
   logic [XW-1:0] napx, pdnx;

   assign is_sleep   = mode_q[1];
   assign pkt_hit    = pkt_valid_i && !is_sleep && (pkt_bcast_i || (pkt_dev_i == dev_id_i));
   assign sleep_req  = pkt_hit && !pkt_bcast_i &&
                       ((pkt_op_i == OP_NAP) || (pkt_op_i == OP_PDN));
   assign want_sleep = sleep_req || pend_q;
   assign want_pdn   = sleep_req ? (pkt_op_i == OP_PDN) : pend_pdn_q;
   assign enter      = !is_sleep && want_sleep && !reentry_busy;
   assign exit_fire  = is_sleep && armed_q && !reexit_busy && wake_strobe_i &&
                       (left_q <= XW'(1));

   pmc_exit_regs #(.XW(XW), .RESET_VAL(1)) i_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .sel_i   (cfg_sel_i),
      .wdata_i (cfg_wdata_i),
      .napx_o  (napx),
      .pdnx_o  (pdnx)
   );

   pmc_wake_rx #(.ID_W(ID_W), .MSB_FIRST(MSB_FIRST)) i_rx (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (is_sleep && !armed_q),
      .strobe_i (wake_strobe_i),
      .bit_i    (wake_bit_i),
      .id_i     (dev_id_i),
      .hit_o    (rx_hit)
   );

   pmc_holdoff #(.DELAY(REENTRY_CYC)) i_reentry (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (exit_fire),
      .busy_o  (reentry_busy)
   );

   pmc_holdoff #(.DELAY(REEXIT_CYC)) i_reexit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (enter),
      .busy_o  (reexit_busy)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q     <= MODE_ATTN;
         prev_q     <= MODE_ATTN;
         pend_q     <= 1'b0;
         pend_pdn_q <= 1'b0;
         armed_q    <= 1'b0;
         left_q     <= '0;
         ready_q    <= 1'b0;
      end else begin
         ready_q <= exit_fire;
         if (enter) begin
            mode_q  <= want_pdn ? MODE_PDN : MODE_NAP;
            prev_q  <= mode_q;
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
         end else if (!is_sleep) begin
            if (sleep_req) begin
               pend_q     <= 1'b1;
               pend_pdn_q <= (pkt_op_i == OP_PDN);
            end
            if (pkt_hit && (pkt_op_i == OP_ATTN)) mode_q <= MODE_ATTN;
            if (pkt_hit && (pkt_op_i == OP_STBY)) mode_q <= MODE_STBY;
         end else if (rx_hit) begin
            armed_q <= 1'b1;
            left_q  <= (mode_q == MODE_PDN) ? pdnx : napx;
         end else if (exit_fire) begin
            mode_q  <= prev_q;
            armed_q <= 1'b0;
         end else if (armed_q && !reexit_busy && wake_strobe_i) begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign mode_o   = mode_q;
   assign accept_o = !is_sleep;
   assign ready_o  = ready_q;
endmodule

// File: rtl/pmc_power_ctrl_chk.sv
module pmc_power_ctrl_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] mode_i,
   input logic [1:0] prev_i,
   input logic       ready_i,
   input logic       reentry_busy_i,
   input logic       reexit_busy_i
);
   assert_leave_sleep_with_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i[1] |=> (mode_i[1] || ready_i));

   assert_ready_after_sleep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_i |-> (!mode_i[1] && $past(mode_i[1])));

   assert_ready_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_i |=> !ready_i);

   assert_restore_prior_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_i |-> (mode_i == $past(prev_i)));

   assert_reentry_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reentry_busy_i && !mode_i[1]) |=> !mode_i[1]);

   assert_reexit_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reexit_busy_i && mode_i[1]) |=> mode_i[1]);
endmodule

bind pmc_power_ctrl pmc_power_ctrl_chk i_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .mode_i         (mode_q),
   .prev_i         (prev_q),
   .ready_i        (ready_o),
   .reentry_busy_i (reentry_busy),
   .reexit_busy_i  (reexit_busy)
);

// File: tb/test_pmc_power_ctrl.sv
module test_pmc_power_ctrl;
   localparam int ID_W = 6;
   localparam int XW   = 4;
   localparam logic [ID_W-1:0] MY_ID = 6'h15;

   typedef struct {
      logic [1:0] mode;
      string      tag;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [ID_W-1:0] pkt_dev = '0;
   logic pkt_valid = 1'b0, pkt_bcast = 1'b0;
   logic [2:0] pkt_op = '0;
   logic cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [XW-1:0] cfg_wdata = '0;
   logic strobe = 1'b0, wbit = 1'b0;
   logic [1:0] mode;
   logic accept, ready;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   exp_t expq[$];
   logic [1:0] last_mode = 2'd0;

   always #2.5 clk = ~clk;

   pmc_power_ctrl i_pmc_power_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .dev_id_i(MY_ID),
      .pkt_valid_i(pkt_valid), .pkt_dev_i(pkt_dev), .pkt_bcast_i(pkt_bcast), .pkt_op_i(pkt_op),
      .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
      .wake_strobe_i(strobe), .wake_bit_i(wbit),
      .mode_o(mode), .accept_o(accept), .ready_o(ready)
   );

   task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_mode(logic [1:0] m, string tag);
      exp_t e;
      e.mode = m;
      e.tag  = tag;
      expq.push_back(e);
   endtask

   // monitor: compares every mode change against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && !done && (mode !== last_mode)) begin
         if (expq.size() == 0) begin
            checks++; fails++;
            $display("FAIL unexpected mode change actual=%0d expected=%0d", mode, last_mode);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(e.tag, 4'(mode), 4'(e.mode));
            if (last_mode[1] && !mode[1]) check("R7 ready on wake", 4'(ready), 4'd1);
         end
         last_mode = mode;
      end
   end

   task automatic send_pkt(logic [ID_W-1:0] dev, logic bc, logic [2:0] op);
      @(negedge clk);
      pkt_valid = 1'b1; pkt_dev = dev; pkt_bcast = bc; pkt_op = op;
      @(negedge clk);
      pkt_valid = 1'b0; pkt_bcast = 1'b0; pkt_op = '0;
   endtask

   task automatic strobe_bit(logic b);
      @(negedge clk);
      strobe = 1'b1; wbit = b;
      @(negedge clk);
      strobe = 1'b0; wbit = 1'b0;
   endtask

   task automatic send_wake(logic [ID_W-1:0] id);
      strobe_bit(1'b1);
      for (int i = ID_W - 1; i >= 0; i--) strobe_bit(id[i]);
   endtask

   task automatic cfg_write(logic sel, logic [XW-1:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mode", 4'(mode), 4'd0);
      check("R1 accept", 4'(accept), 4'd1);
      check("R1 ready", 4'(ready), 4'd0);

      send_pkt(6'h02, 1'b0, 3'd2);
      check("R2 other device ignored", 4'(mode), 4'd0);
      send_pkt(6'h00, 1'b1, 3'd3);
      check("R3 broadcast sleep ignored", 4'(mode), 4'd0);
      expect_mode(2'd1, "R2 broadcast standby");
      send_pkt(6'h00, 1'b1, 3'd2);
      check("R2 standby", 4'(mode), 4'd1);

      expect_mode(2'd2, "R3 nap entry");
      send_pkt(MY_ID, 1'b0, 3'd3);
      check("R3 nap", 4'(mode), 4'd2);
      check("R4 accept low", 4'(accept), 4'd0);
      send_pkt(MY_ID, 1'b0, 3'd1);
      check("R4 packet ignored asleep", 4'(mode), 4'd2);

      repeat (30) @(negedge clk);
      send_wake(6'h2A);
      strobe_bit(1'b0);
      strobe_bit(1'b0);
      check("R5 wrong id no wake", 4'(mode), 4'd2);

      expect_mode(2'd1, "R10 nap exit to standby");
      send_wake(MY_ID);
      check("R6 armed not yet awake", 4'(mode), 4'd2);
      strobe_bit(1'b0);
      check("R6 awake after napx strobes", 4'(mode), 4'd1);
      check("R7 ready high", 4'(ready), 4'd1);
      @(negedge clk);
      check("R7 ready single cycle", 4'(ready), 4'd0);

      expect_mode(2'd0, "R2 attention");
      send_pkt(MY_ID, 1'b0, 3'd1);
      expect_mode(2'd3, "R8 pending power-down entry");
      send_pkt(MY_ID, 1'b0, 3'd4);
      check("R8 entry held", 4'(mode), 4'd0);
      repeat (10) @(negedge clk);
      check("R8 entry after window", 4'(mode), 4'd3);

      cfg_write(1'b1, 4'd3);
      repeat (30) @(negedge clk);
      expect_mode(2'd0, "R10 power-down exit to attention");
      send_wake(MY_ID);
      strobe_bit(1'b0);
      strobe_bit(1'b0);
      check("R9 pdnx=3 still asleep", 4'(mode), 4'd3);
      strobe_bit(1'b0);
      check("R9 awake after 3 strobes", 4'(mode), 4'd0);

      cfg_write(1'b0, 4'd0);
      repeat (10) @(negedge clk);
      expect_mode(2'd2, "R3 nap entry again");
      send_pkt(MY_ID, 1'b0, 3'd3);
      send_wake(MY_ID);
      strobe_bit(1'b0);
      check("R11 strobe in re-exit window ignored", 4'(mode), 4'd2);
      repeat (12) @(negedge clk);
      expect_mode(2'd0, "R10 nap exit to attention");
      strobe_bit(1'b0);
      check("R11 R6 exit after window, zero field", 4'(mode), 4'd0);

      repeat (2) @(negedge clk);
      check("scoreboard drained", 4'(expq.size()), 4'd0);
      finish_run();
   end
endmodule